// File: doc/BRIEF.md
# Segment Register Translation Unit

This block turns a segment-relative reference into a physical address. It holds six on-chip segment registers: code, stack, default data and three extra data segments. Each register stores a base, a limit, three access-rights bits and a flag that marks the segment as an expand-down stack. Software loads these registers through a write port. The hardware never evicts or replaces an entry by itself.

On every access the caller names a segment register, supplies a 32-bit offset and states the kind of access: read, write or instruction fetch. The unit adds the offset to the segment base, modulo 2^32. It compares the offset with the limit. Normal segments use an upper bound. Stack segments use the reversed bound. The unit also checks the access kind against the rights bits. Any violation raises the error flag and forces the address output to zero, so no access is produced.

The lookup path is purely combinational. Register loads take effect at the next rising clock edge.

Top module: `segxlate`

## Requirements
- R1: While reset is asserted, and after it is released, every segment register is cleared to base 0, limit 0, no rights and normal type. As a result, every access before the first load raises `acc_err` with `phys_addr` equal to 0.
- R2: When an access is legal, `phys_addr` equals the selected base plus `acc_off`, truncated to 32 bits. This holds in the same cycle as the access.
- R3: In a normal segment (`wr_stack` = 0 at load), an offset is legal when it is less than or equal to the limit. An offset one above the limit raises `acc_err`.
- R4: In a stack segment (`wr_stack` = 1 at load), an offset is legal only when it is strictly greater than the limit. An offset equal to or below the limit raises `acc_err`.
- R5: The rights bits are encoded as bit 0 = readable, bit 1 = writable and bit 2 = executable. The access kinds are encoded as `acc_kind` 00 = read, 01 = write and 10 = fetch. An access whose right is missing raises `acc_err`. Kind 11 always raises `acc_err`.
- R6: Register indices 0 to 5 are valid. An access naming index 6 or 7 raises `acc_err`. A load naming index 6 or 7 changes no segment register. A load to one segment leaves the other five segments unchanged.
- R7: A load changes the translation only from the next rising clock edge onward. An access in the same cycle as the load still uses the old contents.
- R8: Whenever `acc_err` is 1, `phys_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; loads are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load strobe for a segment register |
| wr_idx | input | 3 | Index of the segment register to load |
| wr_base | input | 32 | Base value to load |
| wr_limit | input | 32 | Limit value to load |
| wr_rights | input | 3 | Rights to load: bit 0 read, bit 1 write, bit 2 execute |
| wr_stack | input | 1 | 1 marks the loaded segment as expand-down stack |
| acc_idx | input | 3 | Segment register named by the access |
| acc_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 reserved |
| acc_off | input | 32 | Offset within the segment |
| phys_addr | output | 32 | Translated address, 0 on error |
| acc_err | output | 1 | Bound, rights or index violation |

## Verification
The address and error outputs follow the access inputs with no register in the path. The bench therefore drives each access just after a falling edge and samples one nanosecond later, well before the next rising edge.

A load is due one rising edge after the strobe. Each load task holds the strobe across exactly one rising edge before any access reads the result.

The same-cycle case checks the old value before the edge and the new value just after it. This pins the one-edge latency of R7 from both sides.

// File: rtl/segxlate.sv
module segxlate #(
  parameter int NSEG = 6,
  parameter int AW   = 32,
  localparam int IW  = 3,
  localparam int RW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_base,
  input  logic [AW-1:0] wr_limit,
  input  logic [RW-1:0] wr_rights,
  input  logic          wr_stack,
  input  logic [IW-1:0] acc_idx,
  input  logic [1:0]    acc_kind,
  input  logic [AW-1:0] acc_off,
  output logic [AW-1:0] phys_addr,
  output logic          acc_err
);

  localparam logic [1:0] K_READ  = 2'b00;
  localparam logic [1:0] K_WRITE = 2'b01;
  localparam logic [1:0] K_FETCH = 2'b10;

  logic [AW-1:0] base_q  [NSEG];
  logic [AW-1:0] limit_q [NSEG];
  logic [RW-1:0] rgt_q   [NSEG];
  logic          stk_q   [NSEG];

  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_seg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          base_q[g]  <= '0;
          limit_q[g] <= '0;
          rgt_q[g]   <= '0;
          stk_q[g]   <= 1'b0;
        end else if (wr_en && wr_idx == IW'(g)) begin
          base_q[g]  <= wr_base;
          limit_q[g] <= wr_limit;
          rgt_q[g]   <= wr_rights;
          stk_q[g]   <= wr_stack;
        end
      end
    end
  endgenerate

  logic [AW-1:0] sel_base, sel_limit;
  logic [RW-1:0] sel_rgt;
  logic          sel_stk, idx_ok;

  always_comb begin
    sel_base  = '0;
    sel_limit = '0;
    sel_rgt   = '0;
    sel_stk   = 1'b0;
    idx_ok    = 1'b0;
    for (int i = 0; i < NSEG; i++) begin
      if (acc_idx == IW'(i)) begin
        sel_base  = base_q[i];
        sel_limit = limit_q[i];
        sel_rgt   = rgt_q[i];
        sel_stk   = stk_q[i];
        idx_ok    = 1'b1;
      end
    end
  end

  logic bound_ok, right_ok;
  assign bound_ok = sel_stk ? (acc_off > sel_limit) : (acc_off <= sel_limit);

  always_comb begin
    case (acc_kind)
      K_READ:  right_ok = sel_rgt[0];
      K_WRITE: right_ok = sel_rgt[1];
      K_FETCH: right_ok = sel_rgt[2];
      default: right_ok = 1'b0;
    endcase
  end

  assign acc_err   = !(idx_ok && bound_ok && right_ok);
  assign phys_addr = acc_err ? '0 : sel_base + acc_off;

endmodule

// File: rtl/segxlate_chk.sv
module segxlate_chk #(
  parameter int NSEG = 6,
  parameter int AW   = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_idx,
  input logic [AW-1:0] wr_base,
  input logic [AW-1:0] wr_limit,
  input logic [2:0]    wr_rights,
  input logic          wr_stack,
  input logic [2:0]    acc_idx,
  input logic [1:0]    acc_kind,
  input logic [AW-1:0] acc_off,
  input logic [AW-1:0] phys_addr,
  input logic          acc_err
);

  AST_ERR_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (phys_addr == '0)); // R8

  AST_BAD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(acc_idx) >= NSEG) |-> acc_err); // R6

  AST_NORMAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) < NSEG && wr_rights == 3'b111 && !wr_stack) |=>
    (!(acc_idx == $past(wr_idx) && acc_kind != 2'b11 && acc_off <= $past(wr_limit))
     || (!acc_err && phys_addr == $past(wr_base) + acc_off))); // R2

  AST_STACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) < NSEG && wr_stack) |=>
    (!(acc_idx == $past(wr_idx) && acc_off <= $past(wr_limit)) || acc_err)); // R4

  AST_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) < NSEG && !wr_rights[2]) |=>
    (!(acc_idx == $past(wr_idx) && acc_kind == 2'b10) || acc_err)); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $stable(acc_idx) && $stable(acc_kind) && $stable(acc_off))
    |-> ($stable(phys_addr) && $stable(acc_err))); // R7

endmodule

bind segxlate segxlate_chk #(.NSEG(NSEG), .AW(AW)) u_chk (.*);

// File: tb/test_segxlate.sv
module test_segxlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [31:0] wr_base, wr_limit;
  logic [2:0]  wr_rights;
  logic        wr_stack;
  logic [2:0]  acc_idx;
  logic [1:0]  acc_kind;
  logic [31:0] acc_off;
  logic [31:0] phys_addr;
  logic        acc_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  segxlate i_segxlate (.*);

  // {idx[3], kind[2], off[32], exp_err, exp_phys[32]}
  localparam int NV = 17;
  localparam logic [69:0] VEC [NV] = '{
    {3'd0, 2'b00, 32'h0000_0010, 1'b0, 32'h0001_0010},  // R2
    {3'd0, 2'b10, 32'h0000_FFFF, 1'b0, 32'h0001_FFFF},  // R3 at limit
    {3'd0, 2'b10, 32'h0001_0000, 1'b1, 32'h0000_0000},  // R3 past limit
    {3'd0, 2'b01, 32'h0000_0000, 1'b1, 32'h0000_0000},  // R5 no write
    {3'd1, 2'b01, 32'h0000_1000, 1'b0, 32'h8000_1000},  // R4 above
    {3'd1, 2'b00, 32'h0000_0FFF, 1'b1, 32'h0000_0000},  // R4 equal
    {3'd1, 2'b00, 32'hFFFF_FFFF, 1'b0, 32'h7FFF_FFFF},  // R2 wrap
    {3'd2, 2'b01, 32'h0000_1800, 1'b0, 32'h0000_0800},  // R2 wrap
    {3'd2, 2'b10, 32'h0000_0000, 1'b1, 32'h0000_0000},  // R5 no exec
    {3'd3, 2'b00, 32'hFFFF_FFFF, 1'b0, 32'h0001_FFFF},  // R3 max limit
    {3'd3, 2'b01, 32'h0000_0000, 1'b1, 32'h0000_0000},  // R5 read-only
    {3'd4, 2'b00, 32'h0000_0000, 1'b0, 32'h1234_0000},  // R3 zero limit
    {3'd4, 2'b00, 32'h0000_0001, 1'b1, 32'h0000_0000},  // R3
    {3'd4, 2'b11, 32'h0000_0000, 1'b1, 32'h0000_0000},  // R5 kind 11
    {3'd5, 2'b00, 32'h0000_0000, 1'b1, 32'h0000_0000},  // R5 no rights
    {3'd6, 2'b00, 32'h0000_0000, 1'b1, 32'h0000_0000},  // R6
    {3'd7, 2'b00, 32'h0000_0000, 1'b1, 32'h0000_0000}   // R6
  };

  task automatic report;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic expect_out(input string req, input logic e_err, input logic [31:0] e_phys);
    checks++;
    if (acc_err !== e_err || phys_addr !== e_phys) begin
      errors++;
      $display("FAIL %s: got err=%0b phys=%h, expected err=%0b phys=%h",
               req, acc_err, phys_addr, e_err, e_phys);
    end
  endtask

  task automatic access(input logic [2:0] idx, input logic [1:0] kind, input logic [31:0] off);
    @(negedge clk);
    acc_idx = idx; acc_kind = kind; acc_off = off;
    #1;
  endtask

  task automatic load(input logic [2:0] idx, input logic [31:0] b, input logic [31:0] l,
                      input logic [2:0] r, input logic s);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_base = b; wr_limit = l; wr_rights = r; wr_stack = s;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run_table(input string pass);
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][69:67], VEC[i][66:65], VEC[i][64:33]);
      expect_out($sformatf("%s entry %0d (R2 R3 R4 R5 R6 R8)", pass, i),
                 VEC[i][32], VEC[i][31:0]);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    report();
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_idx = 0; wr_base = 0; wr_limit = 0;
    wr_rights = 0; wr_stack = 0; acc_idx = 0; acc_kind = 0; acc_off = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: cleared registers deny every access
    for (int s = 0; s < 6; s++) begin
      access(3'(s), 2'b00, 32'h0);
      expect_out("R1 reset state", 1'b1, 32'h0);
    end

    load(3'd0, 32'h0001_0000, 32'h0000_FFFF, 3'b101, 1'b0);
    load(3'd1, 32'h8000_0000, 32'h0000_0FFF, 3'b011, 1'b1);
    load(3'd2, 32'hFFFF_F000, 32'h0000_2000, 3'b011, 1'b0);
    load(3'd3, 32'h0002_0000, 32'hFFFF_FFFF, 3'b001, 1'b0);
    load(3'd4, 32'h1234_0000, 32'h0000_0000, 3'b111, 1'b0);
    load(3'd5, 32'h0000_0000, 32'h0000_0100, 3'b000, 1'b0);
    run_table("pass1");

    // R6: loads to invalid indices must leave all six segments intact
    load(3'd6, 32'hDEAD_0000, 32'hFFFF_FFFF, 3'b000, 1'b1);
    load(3'd7, 32'hBEEF_0000, 32'h0000_0000, 3'b000, 1'b1);
    run_table("pass2 after idx6/7 loads R6");

    // R7: same-cycle access sees old contents, new ones after the edge
    @(negedge clk);
    wr_en = 1; wr_idx = 3'd4; wr_base = 32'h5555_0000; wr_limit = 32'h10;
    wr_rights = 3'b111; wr_stack = 1'b0;
    acc_idx = 3'd4; acc_kind = 2'b00; acc_off = 32'h8;
    #1;
    expect_out("R7 before edge", 1'b1, 32'h0);
    @(posedge clk);
    #1;
    wr_en = 0;
    expect_out("R7 after edge", 1'b0, 32'h5555_0008);

    // R1: reset mid-run clears loaded segments
    @(negedge clk);
    rst_n = 0;
    #1;
    access(3'd4, 2'b00, 32'h8);
    expect_out("R1 during reset", 1'b1, 32'h0);
    @(negedge clk);
    rst_n = 1;
    access(3'd0, 2'b00, 32'h10);
    expect_out("R1 after second reset", 1'b1, 32'h0);

    report();
  end
endmodule